// File: doc/BRIEF.md
# Cascaded 64-Line Priority Encoder

A purely combinational encoder that takes 64 request lines and returns the 6-bit number of the highest-numbered line that is active. Line 63 has the highest priority and line 0 the lowest. The block does not use one flat search. It is a chain of eight identical 8-input slices.

Each slice has an enable input, an enable output and a group-active output. A slice hands its enable down to the next lower slice only when it has no active line itself. A ninth slice encodes which group is active, and this gives the upper three index bits. The lower three bits are the OR of the eight slice indices.

A global enable gates the whole structure. The `valid` output flags a result, and `idle` flags that no line is active or that the block is disabled.

Top module: `prio_enc64`

## Requirements
- R1: When `en` is 1 and at least one bit of `req` is 1, `index` equals the position of the highest set bit of `req` and `valid` is 1.
- R2: Inside a slice, each input is turned into a priority term: the input ANDed with the inverse of every higher input of that slice. At most one of the eight terms is 1 at any time.
- R3: A slice encodes its terms as follows. Index bit 2 is the OR of terms 4 to 7. Bit 1 is the OR of terms 2, 3, 6 and 7. Bit 0 is the OR of terms 1, 3, 5 and 7.
- R4: Slice k covers `req[8k+7:8k]`. A slice is enabled only when every higher slice is enabled and has no active input. Its enable output is 1 exactly when its enable input is 1 and all of its inputs are 0.
- R5: `index[5:3]` is the number of the highest slice that has an active input. This number comes from a ninth slice whose input k is the group-active output of slice k.
- R6: `index[2:0]` is the bitwise OR of the eight slice indices. It equals the position of the winning line within its slice.
- R7: `idle` is 1 exactly when `valid` is 0. When `idle` is 1, `index` is 0.
- R8: When `en` is 0, `valid` is 0, `idle` is 1 and `index` is 0, for any value of `req`.
- R9: A slice whose enable input is 0, or that has no active input, drives its index to 0 and its group-active output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req | input | 64 | Request lines; bit 63 has the highest priority |
| en | input | 1 | Global enable |
| index | output | 6 | Number of the winning request |
| valid | output | 1 | A request won (group-active output of the second-level slice) |
| idle | output | 1 | No request is active, or the block is disabled |

## Verification
The block has no parameters, so the bench builds its only form: 64 lines split into eight slices of eight. This size allows every single-bit pattern and every pair of set bits to be applied. Each pair with its bits in different slices exercises the enable chain and the choice of group. Each pair within one slice exercises the priority terms. Random vectors of varied density, the all-ones vector and the disabled case with arbitrary requests complete the set.

// File: rtl/prio_enc64.sv
module prio_slice8 (
  input  logic [7:0] req,
  input  logic       en_in,
  output logic [2:0] idx,
  output logic       grp,
  output logic       en_out
);
  logic [7:0] term;

  for (genvar i = 0; i < 8; i++) begin : g_term
    assign term[i] = en_in & req[i] & ~(|(req >> (i + 1)));
  end

  assign idx[2] = term[4] | term[5] | term[6] | term[7];
  assign idx[1] = term[2] | term[3] | term[6] | term[7];
  assign idx[0] = term[1] | term[3] | term[5] | term[7];
  assign grp    = en_in & (|req);
  assign en_out = en_in & ~(|req);

  always_comb begin
    assert_term_onehot_R2: assert ($onehot0(term))
      else $error("slice terms not one-hot");
    assert_quiet_slice_R9: assert ((en_in && (|req)) || (idx == 3'd0 && !grp))
      else $error("inactive slice drives index or group");
    assert_enable_pass_R4: assert (!(grp && en_out))
      else $error("slice both active and passing enable");
  end
endmodule

module prio_enc64 (
  input  logic [63:0] req,
  input  logic        en,
  output logic [5:0]  index,
  output logic        valid,
  output logic        idle
);
  logic [8:0] chain;
  logic [7:0] grp;
  logic [2:0] sidx [8];
  logic [2:0] low;
  logic [2:0] high;
  logic       top_eo;

  assign chain[8] = en;

  for (genvar k = 0; k < 8; k++) begin : g_slice
    prio_slice8 u_slice (
      .req   (req[8*k +: 8]),
      .en_in (chain[k+1]),
      .idx   (sidx[k]),
      .grp   (grp[k]),
      .en_out(chain[k])
    );
  end

  prio_slice8 u_group (
    .req   (grp),
    .en_in (en),
    .idx   (high),
    .grp   (valid),
    .en_out(top_eo)
  );

  always_comb begin
    low = 3'd0;
    for (int k = 0; k < 8; k++) low = low | sidx[k];
  end

  assign index = {high, low};
  assign idle  = ~en | chain[0];

  always_comb begin
    assert_idle_valid_R7: assert (idle != valid)
      else $error("idle and valid disagree");
    assert_idle_zero_R7: assert (!idle || index == 6'd0)
      else $error("nonzero index while idle");
    assert_disabled_R8: assert (en || (!valid && index == 6'd0))
      else $error("output while disabled");
    assert_winner_set_R1: assert (!valid || (req[index] && ((req >> index) >> 1) == 64'd0))
      else $error("index is not highest set bit");
    assert_chain_end_R4: assert (top_eo == chain[0])
      else $error("group enable disagrees with chain end");
  end
endmodule

// File: tb/prio_enc64_tb.sv
`timescale 1ns/1ps
module prio_enc64_tb;
  logic        clk = 1'b0;
  logic [63:0] req = 64'd0;
  logic        en = 1'b0;
  logic [5:0]  index;
  logic        valid;
  logic        idle;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_enc64 u_dut (.req(req), .en(en), .index(index), .valid(valid), .idle(idle));

  function automatic int ref_top(input logic [63:0] v);
    ref_top = -1;
    for (int i = 0; i < 64; i++) if (v[i]) ref_top = i;
  endfunction

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] v, input logic e, input string tag);
    int w;
    logic [5:0] ei;
    logic ev;
    @(posedge clk);
    req = v;
    en = e;
    @(negedge clk);
    w = ref_top(v);
    ev = e && (w >= 0);
    ei = ev ? 6'(w) : 6'd0;
    chk({tag, " R5 index[5:3]"}, {3'd0, index[5:3]}, {3'd0, ei[5:3]});
    chk({tag, " R6 index[2:0]"}, {3'd0, index[2:0]}, {3'd0, ei[2:0]});
    chk({tag, " R7 valid"}, {5'd0, valid}, {5'd0, ev});
    chk({tag, " R7 idle"}, {5'd0, idle}, {5'd0, !ev});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    apply(64'd0, 1'b0, "R8 reset state");
    apply(64'd0, 1'b1, "R7 no requests");
    for (int i = 0; i < 64; i++) apply(64'd1 << i, 1'b1, "R1 R3 one-hot");
    for (int i = 1; i < 64; i++)
      for (int j = 0; j < i; j++)
        apply((64'd1 << i) | (64'd1 << j), 1'b1, (i / 8 == j / 8) ? "R2 R9 two-hot in slice" : "R4 two-hot across slices");
    apply({64{1'b1}}, 1'b1, "R1 all ones");
    for (int n = 0; n < 1500; n++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      if (n % 3 == 1) v = v & {$urandom, $urandom} & {$urandom, $urandom};
      if (n % 3 == 2) v = v >> ($urandom % 64);
      apply(v, 1'b1, "R1 random");
    end
    for (int n = 0; n < 200; n++) apply({$urandom, $urandom}, 1'b0, "R8 disabled");
    apply({64{1'b1}}, 1'b0, "R8 disabled all ones");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule